// File: doc/BRIEF.md
# Byte-Serial Command Descriptor Decoder

This block sits beside a storage target's bus-phase sequencer. While the bus is in its command phase, the sequencer hands over the descriptor one byte at a time, using a strobe and a data byte. The block reads the first byte (the opcode) and uses it to decide whether the descriptor is 6 or 10 bytes long. It then collects the rest of the bytes. Once the descriptor is complete, it reports the decoded result:

- the opcode;
- the logical block address;
- the block count;
- the number of bytes to move;
- the phase the sequencer should enter next (data-in, data-out or status) and the status byte.

An opcode the block does not know ends the descriptor at once and asks for a check-condition status.

A start pulse puts the block back to expecting an opcode. The start pulse wins over a byte strobe in the same cycle. The decoded fields are held in registers and stay unchanged until the next descriptor completes. A one-cycle done pulse marks the cycle in which the new fields become valid.

The controller has six states:

| State | Meaning |
|---|---|
| ST_IDLE | After reset; bytes are ignored |
| ST_OPCODE | Waiting for the first byte |
| ST_COLLECT | Gathering the remaining bytes |
| ST_DECODE | Latching the decoded fields |
| ST_DONE | The done pulse |
| ST_HOLD | Fields held; extra bytes are ignored |

Transitions:
- START: from any state to ST_OPCODE when `cmd_start` is high.
- OPC_MORE: ST_OPCODE to ST_COLLECT when an opcode needs more bytes.
- OPC_LAST: ST_OPCODE to ST_DECODE when an opcode is unknown and so is complete after one byte.
- COL_LAST: ST_COLLECT to ST_DECODE on the final byte.
- LATCH: ST_DECODE to ST_DONE.
- RETIRE: ST_DONE to ST_HOLD.

Top module: `cdb_decoder`

## Requirements
- R1: After reset, `done` is 0 and `next_phase`, `status_code`, `cmd_opcode`, `cmd_lba`, `blk_cnt` and `xfer_len` are all zero.
- R2: The descriptor length comes from the opcode.
  - Opcodes 0x25, 0x28, 0x2A and 0x2F take 10 bytes.
  - Opcodes 0x00, 0x03, 0x04, 0x08, 0x09, 0x0A, 0x0C, 0x0D, 0x0E, 0x12, 0x15, 0x1A, 0x1B and 0x3C take 6 bytes.
  - `done` is high for exactly one cycle. That cycle is the second clock cycle after the edge that accepts the final byte, and the fields are valid in it.
- R3: Any other opcode completes after its single byte with `next_phase`=0 (status) and `status_code`=0x02. Later bytes are ignored.
- R4: For 0x08 (read) and 0x0A (write):
  - `cmd_lba` = {byte1[4:0], byte2, byte3}, zero-extended.
  - `blk_cnt` = byte4, except that 0 means 256.
  - `next_phase` is 1 (data-in) for 0x08 and 2 (data-out) for 0x0A.
- R5: For 0x28 (read), 0x2A (write) and 0x2F (verify):
  - `cmd_lba` = bytes 2..5, big-endian.
  - `blk_cnt` = bytes 7..8, big-endian.
  - `next_phase` is 1 for 0x28 and 2 for 0x2A. Verify goes to status 0x00 with `xfer_len` 0.
- R6: For the four read/write opcodes, `xfer_len` = 512 × `blk_cnt`.
- R7: Opcodes 0x00, 0x04, 0x1B, 0x09, 0x0C, 0x0D and 0x0E go to status (`next_phase`=0) with `status_code`=0x00 and `xfer_len`=0.
- R8: The following opcodes give data-in (`next_phase`=1) with fixed lengths: 0x03 gives 13 bytes, 0x25 gives 8 and 0x3C gives 4. Opcode 0x15 gives data-out (`next_phase`=2) with `xfer_len`=0.
- R9: Opcode 0x12 gives data-in with `xfer_len` equal to the smaller of byte4 and 36.
- R10: For opcode 0x1A the page is byte2[5:0].
  - Pages 0x01, 0x03, 0x04 and 0x30 give data-in of 12, 24, 32 and 34 bytes respectively.
  - Any other page gives status with `status_code`=0x02.
- R11: Bytes that arrive after a descriptor completes give no `done` and leave every field unchanged. A `cmd_start` in the middle of a descriptor drops the bytes collected so far.
- R12: Bytes are ignored before the first `cmd_start`, and also when they arrive in the same cycle as a `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Begin a new descriptor |
| byte_valid | input | 1 | Byte strobe, one cycle per byte |
| byte_data | input | 8 | Descriptor byte |
| done | output | 1 | One-cycle pulse: decoded fields are valid |
| next_phase | output | 2 | 0 status, 1 data-in, 2 data-out |
| status_code | output | 8 | Status byte for the status phase |
| cmd_opcode | output | 8 | Opcode of the last descriptor |
| cmd_lba | output | 32 | Logical block address |
| blk_cnt | output | 16 | Block count |
| xfer_len | output | 25 | Bytes in the data phase |

## Verification
The hardest case to reach from the ports is a byte strobe that arrives in the same cycle as `cmd_start`. The bench drives both in one cycle with an unknown opcode on the data lines, then sends a clean six-byte descriptor. If the stray byte had been taken as the opcode, the result would be a check-condition status instead of good status.

An abandoned descriptor is reached by starting a ten-byte read, cutting it off with a new start after three bytes, and then checking that the short descriptor that follows decodes on its own.

A mis-chosen length shows up only as a `done` pulse that comes early or late. The bench therefore samples `done` after every byte, not only at the end.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    parameter int CDB_MAX   = 10;
    parameter int LEN_W     = $clog2(CDB_MAX + 1);
    parameter int LBA_W     = 32;
    parameter int CNT_W     = 16;
    parameter int BLK_SHIFT = 9;
    parameter int XFER_W    = CNT_W + BLK_SHIFT;
    parameter int INQ_MAX   = 36;

    typedef enum logic [1:0] {
        PH_STATUS   = 2'd0,
        PH_DATA_IN  = 2'd1,
        PH_DATA_OUT = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_COLLECT,
        ST_DECODE,
        ST_DONE,
        ST_HOLD
    } ctl_state_e;

    localparam logic [7:0] STS_GOOD  = 8'h00;
    localparam logic [7:0] STS_CHECK = 8'h02;

    localparam logic [7:0] OPC_TUR      = 8'h00;
    localparam logic [7:0] OPC_SENSE    = 8'h03;
    localparam logic [7:0] OPC_FORMAT   = 8'h04;
    localparam logic [7:0] OPC_RD6      = 8'h08;
    localparam logic [7:0] OPC_VND_A    = 8'h09;
    localparam logic [7:0] OPC_WR6      = 8'h0A;
    localparam logic [7:0] OPC_VND_B    = 8'h0C;
    localparam logic [7:0] OPC_VND_C    = 8'h0D;
    localparam logic [7:0] OPC_VND_D    = 8'h0E;
    localparam logic [7:0] OPC_INQ      = 8'h12;
    localparam logic [7:0] OPC_MSEL     = 8'h15;
    localparam logic [7:0] OPC_MSENSE   = 8'h1A;
    localparam logic [7:0] OPC_STARTSTP = 8'h1B;
    localparam logic [7:0] OPC_CAP      = 8'h25;
    localparam logic [7:0] OPC_RD10     = 8'h28;
    localparam logic [7:0] OPC_WR10     = 8'h2A;
    localparam logic [7:0] OPC_VERIFY   = 8'h2F;
    localparam logic [7:0] OPC_RDBUF    = 8'h3C;

    typedef struct packed {
        phase_e              phase;
        logic [7:0]          status;
        logic [LBA_W-1:0]    lba;
        logic [CNT_W-1:0]    blk;
        logic [XFER_W-1:0]   xfer;
    } decode_t;

endpackage

// File: rtl/cdb_len_table.sv
module cdb_len_table
    import cdb_pkg::*;
(
    input  logic [7:0]       opcode,
    output logic [LEN_W-1:0] len
);

    localparam logic [LEN_W-1:0] LEN_SHORT   = LEN_W'(6);
    localparam logic [LEN_W-1:0] LEN_LONG    = LEN_W'(10);
    localparam logic [LEN_W-1:0] LEN_UNKNOWN = LEN_W'(1);

    always_comb begin
        case (opcode)
            OPC_CAP, OPC_RD10, OPC_WR10, OPC_VERIFY:
                len = LEN_LONG;
            OPC_TUR, OPC_SENSE, OPC_FORMAT, OPC_RD6, OPC_WR6, OPC_INQ,
            OPC_MSEL, OPC_MSENSE, OPC_STARTSTP, OPC_RDBUF,
            OPC_VND_A, OPC_VND_B, OPC_VND_C, OPC_VND_D:
                len = LEN_SHORT;
            default:
                len = LEN_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/cdb_byte_store.sv
module cdb_byte_store
    import cdb_pkg::*;
#(
    parameter int DEPTH = CDB_MAX,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   wr,
    input  logic [7:0]             din,
    input  logic [CW-1:0]          limit,
    output logic [DEPTH-1:0][7:0]  bytes,
    output logic [CW-1:0]          count
);

    logic wr_ok;
    assign wr_ok = wr && (count < limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (wr_ok)
            count <= count + CW'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bytes[g] <= '0;
            else if (clear)
                bytes[g] <= '0;
            else if (wr_ok && (count == CW'(g)))
                bytes[g] <= din;
        end
    end

endmodule

// File: rtl/cdb_field_decode.sv
module cdb_field_decode
    import cdb_pkg::*;
(
    input  logic [CDB_MAX-1:0][7:0] b,
    output decode_t                 d
);

    logic [LBA_W-1:0]  lba_short, lba_long;
    logic [CNT_W-1:0]  cnt_short, cnt_long;
    logic [7:0]        inq_len;
    logic [5:0]        page;
    logic              unused_cdb_bits;

    assign lba_short = LBA_W'({b[1][4:0], b[2], b[3]});
    assign lba_long  = {b[2], b[3], b[4], b[5]};
    assign cnt_short = (b[4] == 8'h00) ? CNT_W'(256) : CNT_W'(b[4]);
    assign cnt_long  = {b[7], b[8]};
    assign inq_len   = (b[4] < 8'(INQ_MAX)) ? b[4] : 8'(INQ_MAX);
    assign page      = b[2][5:0];
    assign unused_cdb_bits = ^{b[9], b[6], b[1][7:5], b[2][7:6]};

    function automatic logic [XFER_W-1:0] to_bytes(input logic [CNT_W-1:0] c);
        return XFER_W'(c) << BLK_SHIFT;
    endfunction

    always_comb begin
        d        = '0;
        d.phase  = PH_STATUS;
        d.status = STS_GOOD;
        case (b[0])
            OPC_TUR, OPC_FORMAT, OPC_STARTSTP,
            OPC_VND_A, OPC_VND_B, OPC_VND_C, OPC_VND_D: begin
                d.phase = PH_STATUS;
            end
            OPC_SENSE: begin
                d.phase = PH_DATA_IN;
                d.xfer  = XFER_W'(13);
            end
            OPC_CAP: begin
                d.phase = PH_DATA_IN;
                d.xfer  = XFER_W'(8);
            end
            OPC_RDBUF: begin
                d.phase = PH_DATA_IN;
                d.xfer  = XFER_W'(4);
            end
            OPC_MSEL: begin
                d.phase = PH_DATA_OUT;
            end
            OPC_INQ: begin
                d.phase = PH_DATA_IN;
                d.xfer  = XFER_W'(inq_len);
            end
            OPC_MSENSE: begin
                d.phase = PH_DATA_IN;
                case (page)
                    6'h01:   d.xfer = XFER_W'(12);
                    6'h03:   d.xfer = XFER_W'(24);
                    6'h04:   d.xfer = XFER_W'(32);
                    6'h30:   d.xfer = XFER_W'(34);
                    default: begin
                        d.phase  = PH_STATUS;
                        d.status = STS_CHECK;
                    end
                endcase
            end
            OPC_RD6, OPC_WR6: begin
                d.phase = (b[0] == OPC_RD6) ? PH_DATA_IN : PH_DATA_OUT;
                d.lba   = lba_short;
                d.blk   = cnt_short;
                d.xfer  = to_bytes(cnt_short);
            end
            OPC_RD10, OPC_WR10: begin
                d.phase = (b[0] == OPC_RD10) ? PH_DATA_IN : PH_DATA_OUT;
                d.lba   = lba_long;
                d.blk   = cnt_long;
                d.xfer  = to_bytes(cnt_long);
            end
            OPC_VERIFY: begin
                d.phase = PH_STATUS;
                d.lba   = lba_long;
                d.blk   = cnt_long;
            end
            default: begin
                d.phase  = PH_STATUS;
                d.status = STS_CHECK;
            end
        endcase
    end

endmodule

// File: rtl/cdb_decoder.sv
module cdb_decoder
    import cdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              done,
    output logic [1:0]        next_phase,
    output logic [7:0]        status_code,
    output logic [7:0]        cmd_opcode,
    output logic [LBA_W-1:0]  cmd_lba,
    output logic [CNT_W-1:0]  blk_cnt,
    output logic [XFER_W-1:0] xfer_len
);

    ctl_state_e                 state, state_nxt;
    logic [LEN_W-1:0]           tbl_len, cur_len, eff_len, count;
    logic [CDB_MAX-1:0][7:0]    bytes;
    decode_t                    dec;
    logic                       accept, final_byte;

    cdb_len_table u_len (
        .opcode (byte_data),
        .len    (tbl_len)
    );

    assign eff_len    = (state == ST_OPCODE) ? tbl_len : cur_len;
    assign accept     = byte_valid && !cmd_start &&
                        ((state == ST_OPCODE) || (state == ST_COLLECT));
    assign final_byte = accept && ((count + LEN_W'(1)) == eff_len);

    cdb_byte_store #(.DEPTH(CDB_MAX), .CW(LEN_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cmd_start),
        .wr    (accept),
        .din   (byte_data),
        .limit (eff_len),
        .bytes (bytes),
        .count (count)
    );

    cdb_field_decode u_dec (
        .b (bytes),
        .d (dec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_len <= '0;
        else if (accept && (state == ST_OPCODE))
            cur_len <= tbl_len;
    end

    // next-state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    state_nxt = ST_IDLE;
            ST_OPCODE:  if (accept) state_nxt = final_byte ? ST_DECODE : ST_COLLECT;
            ST_COLLECT: if (final_byte) state_nxt = ST_DECODE;
            ST_DECODE:  state_nxt = ST_DONE;
            ST_DONE:    state_nxt = ST_HOLD;
            ST_HOLD:    state_nxt = ST_HOLD;
            default:    state_nxt = ST_IDLE;
        endcase
        if (cmd_start)
            state_nxt = ST_OPCODE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_phase  <= PH_STATUS;
            status_code <= '0;
            cmd_opcode  <= '0;
            cmd_lba     <= '0;
            blk_cnt     <= '0;
            xfer_len    <= '0;
        end else if (state == ST_DECODE) begin
            next_phase  <= dec.phase;
            status_code <= dec.status;
            cmd_opcode  <= bytes[0];
            cmd_lba     <= dec.lba;
            blk_cnt     <= dec.blk;
            xfer_len    <= dec.xfer;
        end
    end

    assign done = (state == ST_DONE);

endmodule

// File: rtl/cdb_decoder_chk.sv
module cdb_decoder_chk
    import cdb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic              done,
    input logic [1:0]        next_phase,
    input logic [7:0]        status_code,
    input logic [7:0]        cmd_opcode,
    input logic [LBA_W-1:0]  cmd_lba,
    input logic [CNT_W-1:0]  blk_cnt,
    input logic [XFER_W-1:0] xfer_len
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R2

    AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_valid, 2)) else $error("done without final byte"); // R2

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> ($stable(cmd_lba) && $stable(xfer_len) && $stable(next_phase)
                          && $stable(status_code) && $stable(cmd_opcode)))
        else $error("fields changed outside done"); // R11

    AST_CHECK_IS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status_code == 8'h02) |-> (next_phase == 2'd0))
        else $error("check status with data phase"); // R3

    AST_XFER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cmd_opcode == 8'h08 || cmd_opcode == 8'h0A ||
                  cmd_opcode == 8'h28 || cmd_opcode == 8'h2A))
        |-> (xfer_len == (XFER_W'(blk_cnt) << BLK_SHIFT)))
        else $error("byte count not 512x blocks"); // R6

    AST_SHORT_LBA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cmd_opcode == 8'h08 || cmd_opcode == 8'h0A))
        |-> (cmd_lba[LBA_W-1:21] == '0 && blk_cnt != '0 && blk_cnt <= CNT_W'(256)))
        else $error("short form field range"); // R4

    AST_INQ_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_opcode == 8'h12) |-> (xfer_len <= XFER_W'(INQ_MAX)))
        else $error("inquiry length above cap"); // R9

endmodule

bind cdb_decoder cdb_decoder_chk u_chk (.*);

// File: tb/sim_cdb_decoder.sv
module sim_cdb_decoder;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        done;
    logic [1:0]  next_phase;
    logic [7:0]  status_code;
    logic [7:0]  cmd_opcode;
    logic [31:0] cmd_lba;
    logic [15:0] blk_cnt;
    logic [24:0] xfer_len;

    int n_tests = 0;
    int n_fail  = 0;

    typedef logic [7:0] cdb_t [10];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cdb_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .done(done), .next_phase(next_phase), .status_code(status_code),
        .cmd_opcode(cmd_opcode), .cmd_lba(cmd_lba), .blk_cnt(blk_cnt),
        .xfer_len(xfer_len)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        byte_valid = 1'b1;
        byte_data  = v;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic run_cmd(input string req, input bit do_start, input cdb_t c,
                           input int n, input logic [1:0] ph, input logic [7:0] st,
                           input logic [31:0] lba, input logic [15:0] blk,
                           input logic [24:0] xfer);
        int early = 0;
        if (do_start) pulse_start();
        for (int i = 0; i < n; i++) begin
            send_byte(c[i]);
            if (done) early++;
        end
        chk(req, "no early done", early, 0);
        @(negedge clk);
        chk(req, "done pulse", done, 1);
        chk(req, "opcode", cmd_opcode, c[0]);
        chk(req, "phase", next_phase, ph);
        chk(req, "status", status_code, st);
        chk(req, "lba", cmd_lba, lba);
        chk(req, "blocks", blk_cnt, blk);
        chk(req, "xfer", xfer_len, xfer);
        @(negedge clk);
        chk(req, "done one cycle", done, 0);
    endtask

    task automatic test_reset();
        chk("R1", "done", done, 0);
        chk("R1", "phase", next_phase, 0);
        chk("R1", "status", status_code, 0);
        chk("R1", "opcode", cmd_opcode, 0);
        chk("R1", "lba", cmd_lba, 0);
        chk("R1", "blocks", blk_cnt, 0);
        chk("R1", "xfer", xfer_len, 0);
    endtask

    task automatic test_no_start();
        int seen = 0;
        for (int i = 0; i < 6; i++) begin
            send_byte(8'h00);
            if (done) seen++;
        end
        repeat (3) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk("R12", "no done before start", seen, 0);
        chk("R12", "xfer untouched", xfer_len, 0);
    endtask

    task automatic test_start_collision();
        cmd_start  = 1'b1;
        byte_valid = 1'b1;
        byte_data  = 8'h55;
        @(negedge clk);
        cmd_start  = 1'b0;
        byte_valid = 1'b0;
        run_cmd("R12", 1'b0, '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd0, 8'h00, 0, 0, 0);
    endtask

    task automatic test_short_rw();
        run_cmd("R4", 1'b1, '{8'h08,8'hE5,8'hAB,8'hCD,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 32'h0005ABCD, 16'd256, 25'd131072);
        run_cmd("R6", 1'b1, '{8'h0A,8'h00,8'h00,8'h10,8'h03,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd2, 8'h00, 32'h10, 16'd3, 25'd1536);
    endtask

    task automatic test_long_rw();
        run_cmd("R5", 1'b1, '{8'h28,8'h00,8'h12,8'h34,8'h56,8'h78,8'h00,8'h01,8'h02,8'h00},
                10, 2'd1, 8'h00, 32'h12345678, 16'd258, 25'd132096);
        run_cmd("R6", 1'b1, '{8'h2A,8'h00,8'hFF,8'hFF,8'hFF,8'hFF,8'h00,8'hFF,8'hFF,8'h00},
                10, 2'd2, 8'h00, 32'hFFFFFFFF, 16'hFFFF, 25'd33553920);
        run_cmd("R5", 1'b1, '{8'h2F,8'h00,8'h00,8'h00,8'h00,8'h09,8'h00,8'h00,8'h04,8'h00},
                10, 2'd0, 8'h00, 32'd9, 16'd4, 25'd0);
    endtask

    task automatic test_immediate();
        run_cmd("R7", 1'b1, '{8'h04,8'h11,8'h22,8'h33,8'h44,8'h55,8'h00,8'h00,8'h00,8'h00},
                6, 2'd0, 8'h00, 0, 0, 0);
        run_cmd("R7", 1'b1, '{8'h1B,8'h00,8'h00,8'h00,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd0, 8'h00, 0, 0, 0);
        run_cmd("R7", 1'b1, '{8'h0C,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd0, 8'h00, 0, 0, 0);
    endtask

    task automatic test_fixed_len();
        run_cmd("R8", 1'b1, '{8'h03,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 0, 0, 25'd13);
        run_cmd("R8", 1'b1, '{8'h25,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                10, 2'd1, 8'h00, 0, 0, 25'd8);
        run_cmd("R8", 1'b1, '{8'h3C,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 0, 0, 25'd4);
        run_cmd("R8", 1'b1, '{8'h15,8'h00,8'h00,8'h00,8'h0C,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd2, 8'h00, 0, 0, 25'd0);
    endtask

    task automatic test_inquiry();
        run_cmd("R9", 1'b1, '{8'h12,8'h00,8'h00,8'h00,8'd20,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 0, 0, 25'd20);
        run_cmd("R9", 1'b1, '{8'h12,8'h00,8'h00,8'h00,8'd200,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 0, 0, 25'd36);
        run_cmd("R9", 1'b1, '{8'h12,8'h00,8'h00,8'h00,8'd36,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 0, 0, 25'd36);
    endtask

    task automatic test_mode_sense();
        run_cmd("R10", 1'b1, '{8'h1A,8'h00,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 0, 0, 25'd12);
        run_cmd("R10", 1'b1, '{8'h1A,8'h00,8'h03,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 0, 0, 25'd24);
        run_cmd("R10", 1'b1, '{8'h1A,8'h00,8'hC4,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 0, 0, 25'd32);
        run_cmd("R10", 1'b1, '{8'h1A,8'h00,8'h30,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 0, 0, 25'd34);
        run_cmd("R10", 1'b1, '{8'h1A,8'h00,8'h02,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd0, 8'h02, 0, 0, 25'd0);
    endtask

    task automatic test_unknown();
        int seen = 0;
        run_cmd("R3", 1'b1, '{8'h55,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                1, 2'd0, 8'h02, 0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            send_byte(8'h08);
            if (done) seen++;
        end
        chk("R3", "later bytes ignored", seen, 0);
        chk("R3", "status held", status_code, 8'h02);
    endtask

    task automatic test_extra_and_abort();
        int seen = 0;
        run_cmd("R11", 1'b1, '{8'h08,8'h01,8'h02,8'h03,8'h04,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd1, 8'h00, 32'h00010203, 16'd4, 25'd2048);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'hFF);
            if (done) seen++;
        end
        chk("R11", "no done on extra bytes", seen, 0);
        chk("R11", "lba held", cmd_lba, 32'h00010203);
        chk("R11", "xfer held", xfer_len, 25'd2048);
        pulse_start();
        send_byte(8'h28);
        send_byte(8'h00);
        send_byte(8'h00);
        run_cmd("R11", 1'b1, '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd0, 8'h00, 0, 0, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_no_start();
        test_start_collision();
        run_cmd("R2", 1'b1, '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00},
                6, 2'd0, 8'h00, 0, 0, 0);
        test_short_rw();
        test_long_rw();
        test_immediate();
        test_fixed_len();
        test_inquiry();
        test_mode_sense();
        test_unknown();
        test_extra_and_abort();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule